// File: doc/BRIEF.md
# Single-Line MESI Coherence Controller for an Innermost Private Cache

This block keeps one cache line coherent at the level closest to the processor. On one side it takes processor requests (data load, instruction fetch, store, eviction). On the other side it trades messages with the next cache level. It sends read-shared and read-exclusive requests, evictions, invalidate acknowledgements and forwarded data. It receives shared fills, exclusive fills, invalidates and forward requests. The line is held in one of the stable states I, S, E or M. While a miss is outstanding, the line sits in one of four busy states. A line that has never been allocated simply reads as I.

A miss allocates a single transaction record, which also holds pending store data. Every processor request is refused until the fill arrives. Completions are reported as one-cycle pulses. A flag on each completion tells whether the data came from the next level (a fill) or from a hit on the held line. An incoming message takes priority over a processor request in the same cycle. All outputs are registered and appear one cycle after the request or message is accepted.

Top module: `l0c_line_ctrl`

## Requirements
- R1: After reset the line is in I, `req_ready` is 1, and no completion or outgoing message is signalled.
- R2: In I, a load sends GETS (`mo_kind`=0) and enters the data-read wait. An instruction fetch sends GETS and enters a separate fetch wait. A store sends GETX (`mo_kind`=1) and enters the store wait. Request codes on `req_op`: 0 load, 1 fetch, 2 store, 3 evict.
- R3: In S, E or M, a load or fetch completes one cycle after acceptance with `done_remote`=0 and `rd_data` equal to the line. A store in E or M completes the same way, writes the line, sets the dirty bit and leaves the line in M. A store in S sends GETX and enters the upgrade wait.
- R4: While any miss is outstanding, `req_ready` is 0 and no request is consumed. Only one transaction is ever open. After the fill, requests are accepted again.
- R5: An invalidate (`mi_kind`=2) received in I or in any read/store wait is answered with an invalidate acknowledgement (`mo_kind`=3) that carries no data. The pending miss stays open and completes on its fill.
- R6: In a read or fetch wait, a shared fill (`mi_kind`=0) moves the line to S and an exclusive fill (`mi_kind`=1) moves it to E. The load completes with `done_remote`=1 and `rd_data` equal to the fill data. Fills that arrive outside a miss are ignored.
- R7: In the store or upgrade wait, an exclusive fill completes the store with `done_remote`=1. The line then holds the store data, is dirty and is in M.
- R8: An eviction in S, E or M sends PUTX (`mo_kind`=2) with `mo_dirty` equal to the dirty bit. The message carries the line (`mo_has_data`=1) only when dirty; otherwise `mo_data` is 0. The line then reads as I. An eviction in I sends nothing.
- R9: A forward request (`mi_kind`=3) in E or M sends the line as forwarded data (`mo_kind`=4), reports the old dirty bit, clears the dirty bit and moves to S.
- R10: A fill never makes the line dirty, so a line filled by a read evicts with `mo_dirty`=0.
- R11: An invalidate in S, E or M is acknowledged, carries the line only when dirty, and moves the line to I. In the upgrade wait it is acknowledged and the wait continues as a store miss.
- R12: While `mi_valid` is 1, `req_ready` is 0 and the message alone is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_op | input | 2 | Request code: 0 load, 1 fetch, 2 store, 3 evict |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Request accepted this cycle when valid |
| done_load | output | 1 | Load or fetch completed |
| done_store | output | 1 | Store completed |
| done_remote | output | 1 | Completion was served by a fill |
| rd_data | output | DW | Line value at completion |
| mi_valid | input | 1 | Incoming message present, always consumed |
| mi_kind | input | 2 | 0 shared fill, 1 exclusive fill, 2 invalidate, 3 forward request |
| mi_data | input | DW | Fill data |
| mo_valid | output | 1 | Outgoing message present |
| mo_kind | output | 3 | 0 GETS, 1 GETX, 2 PUTX, 3 invalidate ack, 4 forwarded data |
| mo_dirty | output | 1 | Dirty flag of the line at send time |
| mo_has_data | output | 1 | Message carries the line |
| mo_data | output | DW | Line data, zero when not carried |

## Verification
The assertions assume that the next level sends a fill only for a miss it was asked to serve. They also assume that only the kinds named in R5, R6, R7, R9 and R11 arrive in the matching states, and that processor requests arrive only through the ready handshake. The bench never overlaps a fill with another fill. It places forward requests only in E or M. It presents one stimulus per cycle, so every message targets the state set up by the preceding, already checked steps. It sweeps every stable starting state against every request code and reaches each starting state through the normal miss paths.

// File: rtl/l0c_pkg.sv
package l0c_pkg;

  typedef enum logic [2:0] {
    ST_I   = 3'd0,
    ST_S   = 3'd1,
    ST_E   = 3'd2,
    ST_M   = 3'd3,
    ST_IS  = 3'd4,
    ST_IIS = 3'd5,
    ST_IM  = 3'd6,
    ST_SM  = 3'd7
  } line_st_t;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_FETCH = 2'd1,
    OP_STORE = 2'd2,
    OP_EVICT = 2'd3
  } req_op_t;

  typedef enum logic [1:0] {
    MI_FILL_SH = 2'd0,
    MI_FILL_EX = 2'd1,
    MI_INVAL   = 2'd2,
    MI_FWD     = 2'd3
  } in_kind_t;

  typedef enum logic [2:0] {
    MO_GETS   = 3'd0,
    MO_GETX   = 3'd1,
    MO_PUTX   = 3'd2,
    MO_INVACK = 3'd3,
    MO_FWDDAT = 3'd4
  } out_kind_t;

  typedef struct packed {
    line_st_t  nxt;
    logic      ld_done;
    logic      st_done;
    logic      remote;
    logic      send;
    out_kind_t kind;
    logic      has_data;
    logic      out_dirty;
    logic      wr_fill;
    logic      wr_pend;
    logic      wr_store;
    logic      set_dirty;
    logic      clr_dirty;
    logic      alloc;
    logic      free;
  } act_t;

endpackage

// File: rtl/l0c_decide.sv
module l0c_decide
  import l0c_pkg::*;
(
  input  line_st_t state,
  input  logic     dirty,
  input  logic     req_fire,
  input  logic [1:0] req_op,
  input  logic     mi_valid,
  input  logic [1:0] mi_kind,
  output act_t     act
);

  always_comb begin
    act     = '0;
    act.nxt = state;
    if (mi_valid) begin
      case (in_kind_t'(mi_kind))
        MI_FILL_SH: begin
          if (state inside {ST_IS, ST_IIS}) begin
            act.nxt = ST_S; act.wr_fill = 1'b1; act.ld_done = 1'b1;
            act.remote = 1'b1; act.free = 1'b1;
          end
        end
        MI_FILL_EX: begin
          if (state inside {ST_IS, ST_IIS}) begin
            act.nxt = ST_E; act.wr_fill = 1'b1; act.ld_done = 1'b1;
            act.remote = 1'b1; act.free = 1'b1;
          end else if (state inside {ST_IM, ST_SM}) begin
            act.nxt = ST_M; act.wr_pend = 1'b1; act.set_dirty = 1'b1;
            act.st_done = 1'b1; act.remote = 1'b1; act.free = 1'b1;
          end
        end
        MI_INVAL: begin
          act.send = 1'b1;
          act.kind = MO_INVACK;
          if (state inside {ST_S, ST_E, ST_M}) begin
            act.has_data  = dirty;
            act.out_dirty = dirty;
            act.clr_dirty = 1'b1;
            act.nxt       = ST_I;
          end else if (state == ST_SM) begin
            act.nxt = ST_IM;
          end
        end
        default: begin
          if (state inside {ST_E, ST_M}) begin
            act.send = 1'b1; act.kind = MO_FWDDAT; act.has_data = 1'b1;
            act.out_dirty = dirty; act.clr_dirty = 1'b1; act.nxt = ST_S;
          end
        end
      endcase
    end else if (req_fire) begin
      case (state)
        ST_I: begin
          case (req_op_t'(req_op))
            OP_LOAD:  begin act.send = 1'b1; act.kind = MO_GETS; act.nxt = ST_IS;  act.alloc = 1'b1; end
            OP_FETCH: begin act.send = 1'b1; act.kind = MO_GETS; act.nxt = ST_IIS; act.alloc = 1'b1; end
            OP_STORE: begin act.send = 1'b1; act.kind = MO_GETX; act.nxt = ST_IM;  act.alloc = 1'b1; end
            default:  act.nxt = ST_I;
          endcase
        end
        ST_S, ST_E, ST_M: begin
          case (req_op_t'(req_op))
            OP_LOAD, OP_FETCH: act.ld_done = 1'b1;
            OP_STORE: begin
              if (state == ST_S) begin
                act.send = 1'b1; act.kind = MO_GETX; act.nxt = ST_SM; act.alloc = 1'b1;
              end else begin
                act.wr_store = 1'b1; act.set_dirty = 1'b1; act.st_done = 1'b1; act.nxt = ST_M;
              end
            end
            default: begin
              act.send = 1'b1; act.kind = MO_PUTX; act.has_data = dirty;
              act.out_dirty = dirty; act.clr_dirty = 1'b1; act.nxt = ST_I;
            end
          endcase
        end
        default: act.nxt = state;
      endcase
    end
  end

endmodule

// File: rtl/l0c_line.sv
module l0c_line #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          set_dirty,
  input  logic          clr_dirty,
  output logic [DW-1:0] q,
  output logic          dirty
);

  always_ff @(posedge clk) begin
    if (wr_en) q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)            dirty <= 1'b0;
    else if (set_dirty) dirty <= 1'b1;
    else if (clr_dirty) dirty <= 1'b0;
  end

  AST_DIRTY_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !(set_dirty && clr_dirty)); // R9

endmodule

// File: rtl/l0c_txn.sv
module l0c_txn #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  input  logic          free,
  input  logic [DW-1:0] wdata_in,
  output logic          valid_q,
  output logic [DW-1:0] wdata_q
);

  always_ff @(posedge clk) begin
    if (rst)        valid_q <= 1'b0;
    else if (alloc) valid_q <= 1'b1;
    else if (free)  valid_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (alloc) wdata_q <= wdata_in;
  end

  AST_ONE_MISS: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !valid_q); // R4
  AST_FREE_OPEN: assert property (@(posedge clk) disable iff (rst)
    free |-> valid_q); // R4

endmodule

// File: rtl/l0c_line_ctrl.sv
module l0c_line_ctrl
  import l0c_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done_load,
  output logic          done_store,
  output logic          done_remote,
  output logic [DW-1:0] rd_data,
  input  logic          mi_valid,
  input  logic [1:0]    mi_kind,
  input  logic [DW-1:0] mi_data,
  output logic          mo_valid,
  output logic [2:0]    mo_kind,
  output logic          mo_dirty,
  output logic          mo_has_data,
  output logic [DW-1:0] mo_data
);

  line_st_t      state_q;
  act_t          act;
  logic          busy;
  logic          req_fire;
  logic          txn_open;
  logic [DW-1:0] txn_wdata;
  logic [DW-1:0] line_q;
  logic          line_dirty;
  logic          wr_en;
  logic [DW-1:0] wr_data;

  assign busy      = state_q inside {ST_IS, ST_IIS, ST_IM, ST_SM};
  assign req_ready = !busy && !mi_valid;
  assign req_fire  = req_valid && req_ready;

  l0c_decide u_decide (
    .state    (state_q),
    .dirty    (line_dirty),
    .req_fire (req_fire),
    .req_op   (req_op),
    .mi_valid (mi_valid),
    .mi_kind  (mi_kind),
    .act      (act)
  );

  l0c_txn #(.DW(DW)) u_txn (
    .clk      (clk),
    .rst      (rst),
    .alloc    (act.alloc),
    .free     (act.free),
    .wdata_in (req_wdata),
    .valid_q  (txn_open),
    .wdata_q  (txn_wdata)
  );

  assign wr_en   = act.wr_fill || act.wr_pend || act.wr_store;
  assign wr_data = act.wr_fill ? mi_data : (act.wr_pend ? txn_wdata : req_wdata);

  l0c_line #(.DW(DW)) u_line (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .set_dirty (act.set_dirty),
    .clr_dirty (act.clr_dirty),
    .q         (line_q),
    .dirty     (line_dirty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_I;
      done_load   <= 1'b0;
      done_store  <= 1'b0;
      done_remote <= 1'b0;
      rd_data     <= '0;
      mo_valid    <= 1'b0;
      mo_kind     <= 3'd0;
      mo_dirty    <= 1'b0;
      mo_has_data <= 1'b0;
      mo_data     <= '0;
    end else begin
      state_q     <= act.nxt;
      done_load   <= act.ld_done;
      done_store  <= act.st_done;
      done_remote <= act.remote;
      if (act.ld_done || act.st_done) rd_data <= wr_en ? wr_data : line_q;
      mo_valid    <= act.send;
      mo_kind     <= act.kind;
      mo_dirty    <= act.out_dirty;
      mo_has_data <= act.has_data;
      mo_data     <= act.has_data ? line_q : '0;
    end
  end

  AST_TXN_MATCHES_WAIT: assert property (@(posedge clk) disable iff (rst)
    txn_open == busy); // R4
  AST_NO_HIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> !((done_load || done_store) && !done_remote)); // R4
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_load, done_store})); // R3
  AST_INV_KEEPS_MISS: assert property (@(posedge clk) disable iff (rst)
    (mi_valid && mi_kind == 2'd2 && state_q inside {ST_I, ST_IS, ST_IIS, ST_IM})
    |=> (mo_valid && mo_kind == 3'd3 && !mo_has_data && state_q == $past(state_q))); // R5
  AST_LOAD_FILL: assert property (@(posedge clk) disable iff (rst)
    (mi_valid && mi_kind inside {2'd0, 2'd1} && state_q inside {ST_IS, ST_IIS})
    |=> (done_load && done_remote && rd_data == $past(mi_data))); // R6
  AST_STORE_FILL: assert property (@(posedge clk) disable iff (rst)
    (mi_valid && mi_kind == 2'd1 && state_q inside {ST_IM, ST_SM})
    |=> (done_store && done_remote && line_dirty && state_q == ST_M)); // R7
  AST_CLEAN_PUTX_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (mo_valid && mo_kind == 3'd2 && !mo_dirty) |-> (mo_data == '0)); // R8
  AST_MSG_FIRST: assert property (@(posedge clk) disable iff (rst)
    (mi_valid && !busy) |=> !(done_load && !done_remote)); // R12

endmodule

// File: tb/sim_l0c_line_ctrl.sv
`timescale 1ns/1ps
module sim_l0c_line_ctrl;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready;
  logic          done_load, done_store, done_remote;
  logic [DW-1:0] rd_data;
  logic          mi_valid = 1'b0;
  logic [1:0]    mi_kind = 2'd0;
  logic [DW-1:0] mi_data = '0;
  logic          mo_valid, mo_dirty, mo_has_data;
  logic [2:0]    mo_kind;
  logic [DW-1:0] mo_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  logic          s_rdy, s_ld, s_st, s_rem, s_mv, s_dirty, s_hd;
  logic [2:0]    s_mk;
  logic [DW-1:0] s_rd, s_md;

  always #2.5 clk = ~clk;

  l0c_line_ctrl #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_wdata(req_wdata),
    .req_ready(req_ready), .done_load(done_load), .done_store(done_store),
    .done_remote(done_remote), .rd_data(rd_data), .mi_valid(mi_valid), .mi_kind(mi_kind),
    .mi_data(mi_data), .mo_valid(mo_valid), .mo_kind(mo_kind), .mo_dirty(mo_dirty),
    .mo_has_data(mo_has_data), .mo_data(mo_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // drive at a falling edge, let one rising edge pass, snapshot at the next falling edge
  task automatic step(input bit rv, input logic [1:0] op, input logic [DW-1:0] wd,
                      input bit mv, input logic [1:0] mk, input logic [DW-1:0] md);
    req_valid = rv; req_op = op; req_wdata = wd;
    mi_valid = mv; mi_kind = mk; mi_data = md;
    #1;
    s_rdy = req_ready;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; mi_valid = 1'b0;
    s_ld = done_load; s_st = done_store; s_rem = done_remote; s_rd = rd_data;
    s_mv = mo_valid; s_mk = mo_kind; s_dirty = mo_dirty; s_hd = mo_has_data; s_md = mo_data;
  endtask

  task automatic req(input logic [1:0] op, input logic [DW-1:0] wd);
    step(1'b1, op, wd, 1'b0, 2'd0, '0);
  endtask

  task automatic msg(input logic [1:0] mk, input logic [DW-1:0] md);
    step(1'b0, 2'd0, '0, 1'b1, mk, md);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b0, 2'd0, '0, 1'b0, 2'd0, '0);
    step(1'b0, 2'd0, '0, 1'b0, 2'd0, '0);
    rst = 1'b0;
  endtask

  // 0:I 1:S 2:E 3:M, returns line value
  task automatic goto_state(input int st, output logic [DW-1:0] line);
    do_reset();
    line = '0;
    case (st)
      1: begin req(2'd0, '0); line = 16'h5A01; msg(2'd0, line); end
      2: begin req(2'd0, '0); line = 16'h5A02; msg(2'd1, line); end
      3: begin line = 16'h3C03; req(2'd2, line); msg(2'd1, 16'hDEAD); end
      default: ;
    endcase
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      report();
    end
  end

  initial begin
    logic [DW-1:0] line;
    @(negedge clk);
    do_reset();
    step(1'b0, 2'd0, '0, 1'b0, 2'd0, '0);
    chk(s_rdy && !s_mv && !s_ld && !s_st, "R1 reset idle",
        {s_rdy, s_mv, s_ld, s_st}, 4'b1000);

    // sweep: every stable start state against every request code
    for (int st = 0; st < 4; st++) begin
      for (int op = 0; op < 4; op++) begin
        logic [DW-1:0] wd;
        logic [DW-1:0] fv;
        wd = 16'h7700 + DW'(op * 16 + st);
        fv = 16'h9100 + DW'(op * 16 + st);
        goto_state(st, line);
        req(op[1:0], wd);
        chk(s_rdy, "R4 ready in stable state", {31'd0, s_rdy}, 1);
        if (op < 2) begin
          if (st == 0) begin
            chk(s_mv && s_mk == 3'd0, "R2 miss sends GETS", {s_mv, s_mk}, 4'b1000);
            msg(op == 0 ? 2'd0 : 2'd1, fv);
            chk(s_ld && s_rem && s_rd == fv, "R6 fill completes load", {s_ld, s_rem, s_rd}, {2'b11, fv});
            req(2'd2, wd);
            if (op == 0) chk(s_mv && s_mk == 3'd1, "R6 shared fill gives S", {s_mv, s_mk}, 4'b1001);
            else         chk(s_st && !s_rem && !s_mv, "R6 exclusive fill gives E", {s_st, s_rem, s_mv}, 3'b100);
          end else begin
            chk(s_ld && !s_rem && !s_mv && s_rd == line, "R3 load hit",
                {s_ld, s_rem, s_mv, s_rd}, {3'b100, line});
          end
        end else if (op == 2) begin
          if (st <= 1) begin
            chk(s_mv && s_mk == 3'd1, "R2 R3 store miss sends GETX", {s_mv, s_mk}, 4'b1001);
            msg(2'd1, fv);
            chk(s_st && s_rem && s_rd == wd, "R7 fill completes store", {s_st, s_rem, s_rd}, {2'b11, wd});
          end else begin
            chk(s_st && !s_rem && !s_mv && s_rd == wd, "R3 store hit",
                {s_st, s_rem, s_mv, s_rd}, {3'b100, wd});
          end
          req(2'd3, '0);
          chk(s_mv && s_mk == 3'd2 && s_dirty && s_hd && s_md == wd, "R7 store leaves M dirty",
              {s_mv, s_mk, s_dirty, s_hd, s_md}, {1'b1, 3'd2, 2'b11, wd});
        end else begin
          if (st == 0) begin
            chk(!s_mv && !s_ld && !s_st, "R8 evict in I silent", {s_mv, s_ld, s_st}, 0);
          end else begin
            logic dty;
            dty = (st == 3);
            chk(s_mv && s_mk == 3'd2 && s_dirty == dty && s_hd == dty && s_md == (dty ? line : '0),
                "R8 R10 PUTX fields", {s_mv, s_mk, s_dirty, s_hd, s_md},
                {1'b1, 3'd2, dty, dty, (dty ? line : 16'h0)});
            req(2'd0, '0);
            chk(s_mv && s_mk == 3'd0, "R8 line reads I after evict", {s_mv, s_mk}, 4'b1000);
          end
        end
      end
    end

    // R4 stall and R5 invalidate during a miss
    do_reset();
    req(2'd1, '0);
    chk(s_mv && s_mk == 3'd0, "R2 fetch sends GETS", {s_mv, s_mk}, 4'b1000);
    req(2'd2, 16'h1111);
    chk(!s_rdy && !s_mv && !s_st, "R4 store stalled", {s_rdy, s_mv, s_st}, 0);
    msg(2'd2, '0);
    chk(s_mv && s_mk == 3'd3 && !s_hd, "R5 inval in fetch wait acked", {s_mv, s_mk, s_hd}, 5'b10110);
    msg(2'd0, 16'h2222);
    chk(s_ld && s_rem && s_rd == 16'h2222, "R5 miss survives inval", {s_ld, s_rem, s_rd}, {2'b11, 16'h2222});
    req(2'd2, 16'h3333);
    chk(s_rdy && s_mv && s_mk == 3'd1, "R4 accepted after fill", {s_rdy, s_mv, s_mk}, 5'b11001);
    do_reset();
    msg(2'd2, '0);
    chk(s_mv && s_mk == 3'd3 && !s_hd, "R5 inval in I acked", {s_mv, s_mk, s_hd}, 5'b10110);

    // R9 forward in M and in E
    goto_state(3, line);
    msg(2'd3, '0);
    chk(s_mv && s_mk == 3'd4 && s_hd && s_dirty && s_md == line, "R9 forward from M",
        {s_mv, s_mk, s_hd, s_dirty, s_md}, {1'b1, 3'd4, 2'b11, line});
    req(2'd3, '0);
    chk(s_mv && s_mk == 3'd2 && !s_dirty && !s_hd, "R9 dirty cleared", {s_mv, s_mk, s_dirty, s_hd}, 6'b101000);
    goto_state(2, line);
    msg(2'd3, '0);
    chk(s_mv && s_mk == 3'd4 && s_hd && !s_dirty && s_md == line, "R9 forward from E",
        {s_mv, s_mk, s_hd, s_dirty, s_md}, {1'b1, 3'd4, 2'b10, line});
    req(2'd2, 16'h4444);
    chk(s_mv && s_mk == 3'd1, "R9 forward leaves S", {s_mv, s_mk}, 4'b1001);

    // R11 invalidate of a held line, and in the upgrade wait
    goto_state(3, line);
    msg(2'd2, '0);
    chk(s_mv && s_mk == 3'd3 && s_hd && s_md == line, "R11 inval M carries data",
        {s_mv, s_mk, s_hd, s_md}, {1'b1, 3'd3, 1'b1, line});
    req(2'd0, '0);
    chk(s_mv && s_mk == 3'd0, "R11 M inval leaves I", {s_mv, s_mk}, 4'b1000);
    goto_state(1, line);
    msg(2'd2, '0);
    chk(s_mv && s_mk == 3'd3 && !s_hd && s_md == '0, "R11 inval S no data", {s_mv, s_mk, s_hd}, 5'b10110);
    goto_state(1, line);
    req(2'd2, 16'h5555);
    msg(2'd2, '0);
    chk(s_mv && s_mk == 3'd3, "R11 inval in upgrade wait", {s_mv, s_mk}, 4'b1011);
    msg(2'd1, 16'h0BAD);
    chk(s_st && s_rem && s_rd == 16'h5555, "R11 upgrade completes as store", {s_st, s_rem, s_rd}, {2'b11, 16'h5555});

    // R12 message wins over a request
    goto_state(1, line);
    step(1'b1, 2'd0, '0, 1'b1, 2'd2, '0);
    chk(!s_rdy && !s_ld && s_mv && s_mk == 3'd3, "R12 message first",
        {s_rdy, s_ld, s_mv, s_mk}, 6'b001011);

    // R6 stray fill ignored in a stable state
    goto_state(2, line);
    msg(2'd0, 16'hBEEF);
    chk(!s_ld && !s_mv, "R6 stray fill silent", {s_ld, s_mv}, 0);
    req(2'd0, '0);
    chk(s_ld && s_rd == line, "R6 stray fill not written", s_rd, line);

    done_flag = 1'b1;
    report();
  end

endmodule